// File: doc/BRIEF.md
# Machine-Cycle Timer / Falling-Edge Event Counter

This block is a 16-bit up-counter, held as a low byte and a high byte, with two ways of counting. A built-in prescaler divides the oscillator clock into machine cycles. One machine cycle is `DIV_RATIO` oscillator clocks, 12 by default. With `evt_mode` low the block is a timer: it adds one at every machine-cycle boundary. With `evt_mode` high it is an event counter. In that mode it samples `evt_pin` once at each machine-cycle boundary and counts a falling transition only when one sample reads high and the next reads low.

When the count rolls over, the block sets a sticky overflow flag. Only a software write clears that flag. Software can load either byte at any time, and a load takes priority over a count in the same clock. `run_en` gates every increment, but the pin sampler keeps running while counting is stopped.

The sampler is a two-state machine. `SMP_LOW` means the last sample read 0 and `SMP_HIGH` means it read 1. At a boundary, a 1 moves it from `SMP_LOW` to `SMP_HIGH` (transition *rise_seen*). A 0 moves it from `SMP_HIGH` to `SMP_LOW` (transition *fall_seen*), and that move also raises a pending event. At a boundary with no change in level the state is held (*hold*). The pending event is applied at the next boundary, so the new count appears one machine cycle after the transition was seen.

Top module: `evtimer16`

## Requirements
- R1: While `rst_n` is low, and after reset until the first count, `{cnt_hi,cnt_lo}` reads 0x0000 and `ovf_flag` reads 0. The sampler starts in `SMP_LOW`.
- R2: With `evt_mode`=0 and `run_en`=1, the count rises by exactly one every `DIV_RATIO` (12) oscillator clocks.
- R3: With `evt_mode`=1, `evt_pin` is sampled at the clock edge that closes each machine cycle. One count is made for each pair of consecutive samples that reads 1 and then 0.
- R4: The count that results from a falling transition becomes visible at the machine-cycle boundary after the boundary that sampled the 0, not earlier.
- R5: A low pulse that starts and ends between two sampling edges is not counted. A pin that toggles every machine cycle yields one count per 24 oscillator clocks.
- R6: With `run_en`=0 the count does not change in either mode, apart from writes. The pin is still sampled, so a high seen while stopped followed by a low seen after `run_en` returns to 1 is counted.
- R7: An increment from 0xFFFF gives 0x0000 and sets `ovf_flag` to 1. Counting then continues from 0.
- R8: `ovf_flag` keeps its value until `ovf_wr`=1 loads `ovf_wdata` into it. If a rollover and an `ovf_wr` fall in the same clock, the flag ends at 1.
- R9: `wr_lo`=1 loads `wr_data[7:0]` into `cnt_lo` and `wr_hi`=1 loads `wr_data[15:8]` into `cnt_hi`, each at the next clock edge. In a clock where either strobe is high, no increment takes place and the unwritten byte keeps its value.
- R10: Without a write, the count changes only at machine-cycle boundaries, and by at most one per boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Increment enable for both modes |
| evt_mode | input | 1 | 0 selects timer, 1 selects falling-edge event counter |
| evt_pin | input | 1 | External event input, synchronous to `clk` |
| wr_lo | input | 1 | Load the low byte from `wr_data[7:0]` |
| wr_hi | input | 1 | Load the high byte from `wr_data[15:8]` |
| wr_data | input | 16 | Write data for the byte loads |
| ovf_wr | input | 1 | Write strobe for the overflow flag |
| ovf_wdata | input | 1 | Value written to the overflow flag |
| cnt_lo | output | 8 | Low byte of the count |
| cnt_hi | output | 8 | High byte of the count |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bound checker holds a set of properties on every clock. The count may move only at a machine-cycle boundary and by at most one step. A stopped counter holds its value. A byte load lands exactly as written. The flag stays set until software writes it, and it can rise on its own only when the count reads zero. The checker also confirms that boundaries never occur back to back. Other behaviour depends on what happened several machine cycles earlier, and only the directed scenarios show it. These scenarios cover the one-cycle delay between seeing a fall and counting it, the rejection of short glitches, the limit of one event per 24 clocks, samples taken while stopped, and the two same-clock priority cases.

// File: rtl/evtc_pkg.sv
package evtc_pkg;

    // Level seen at the most recent machine-cycle sample of the event pin
    typedef enum logic [0:0] {
        SMP_LOW  = 1'b0,
        SMP_HIGH = 1'b1
    } smp_state_t;

endpackage

// File: rtl/evtc_prescale.sv
module evtc_prescale #(
    parameter int DIV_RATIO = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DW = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV_RATIO - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // High during the final oscillator clock of each machine cycle
    assign tick = (div_q == LAST);

endmodule

// File: rtl/evtc_sampler.sv
module evtc_sampler
    import evtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic evt_pend
);
    smp_state_t state_q, state_d;
    logic       fall_seen;
    logic       pend_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SMP_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: rise_seen, fall_seen or hold
    always_comb begin
        state_d   = state_q;
        fall_seen = 1'b0;
        unique case (state_q)
            SMP_LOW: begin
                if (tick && pin) begin
                    state_d = SMP_HIGH;
                end
            end
            SMP_HIGH: begin
                if (tick && !pin) begin
                    state_d   = SMP_LOW;
                    fall_seen = 1'b1;
                end
            end
            default: state_d = SMP_LOW;
        endcase
    end

    // Output: the event stays pending for one machine cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (tick) begin
            pend_q <= fall_seen;
        end
    end

    assign evt_pend = pend_q;

endmodule

// File: rtl/evtc_core.sv
module evtc_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run_en,
    input  logic             evt_mode,
    input  logic             evt_pend,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ovf_wr,
    input  logic             ovf_wdata,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    localparam int HALF = CNT_W / 2;

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             wr_any;
    logic             inc;
    logic             wrap;

    assign wr_any = wr_lo | wr_hi;
    assign inc    = tick & run_en & (evt_mode ? evt_pend : 1'b1) & ~wr_any;
    assign wrap   = inc & (&cnt_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_any) begin
            if (wr_lo) cnt_q[HALF-1:0]     <= wr_data[HALF-1:0];
            if (wr_hi) cnt_q[CNT_W-1:HALF] <= wr_data[CNT_W-1:HALF];
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // A rollover beats a software write in the same clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (wrap) begin
            ovf_q <= 1'b1;
        end else if (ovf_wr) begin
            ovf_q <= ovf_wdata;
        end
    end

    assign count = cnt_q;
    assign ovf   = ovf_q;

endmodule

// File: rtl/evtimer16.sv
module evtimer16 #(
    parameter int DIV_RATIO = 12,
    parameter int CNT_W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               evt_mode,
    input  logic               evt_pin,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic               ovf_wr,
    input  logic               ovf_wdata,
    output logic [CNT_W/2-1:0] cnt_lo,
    output logic [CNT_W/2-1:0] cnt_hi,
    output logic               ovf_flag
);
    localparam int HALF = CNT_W / 2;

    logic             mc_tick;
    logic             evt_pend;
    logic [CNT_W-1:0] count;

    evtc_prescale #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (mc_tick)
    );

    evtc_sampler u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (mc_tick),
        .pin      (evt_pin),
        .evt_pend (evt_pend)
    );

    evtc_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (mc_tick),
        .run_en    (run_en),
        .evt_mode  (evt_mode),
        .evt_pend  (evt_pend),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .wr_data   (wr_data),
        .ovf_wr    (ovf_wr),
        .ovf_wdata (ovf_wdata),
        .count     (count),
        .ovf       (ovf_flag)
    );

    assign cnt_lo = count[HALF-1:0];
    assign cnt_hi = count[CNT_W-1:HALF];

endmodule

// File: rtl/evtimer16_chk.sv
module evtimer16_chk #(
    parameter int CNT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mc_tick,
    input logic               run_en,
    input logic               wr_lo,
    input logic               wr_hi,
    input logic [CNT_W-1:0]   wr_data,
    input logic               ovf_wr,
    input logic [CNT_W/2-1:0] cnt_lo,
    input logic [CNT_W/2-1:0] cnt_hi,
    input logic               ovf_flag
);
    localparam int HALF = CNT_W / 2;

    logic [CNT_W-1:0] cnt;
    assign cnt = {cnt_hi, cnt_lo};

    // R10
    between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mc_tick && !wr_lo && !wr_hi) |=> $stable(cnt));

    // R10
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi) |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1)));

    // R10
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mc_tick |=> !mc_tick);

    // R6
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_lo && !wr_hi) |=> $stable(cnt));

    // R9
    lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> cnt_lo == $past(wr_data[HALF-1:0]));

    // R9
    hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> cnt_hi == $past(wr_data[CNT_W-1:HALF]));

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_wr) |=> ovf_flag);

    // R7
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_flag && !ovf_wr) |=> (!ovf_flag || cnt == '0));

endmodule

bind evtimer16 evtimer16_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mc_tick  (mc_tick),
    .run_en   (run_en),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .wr_data  (wr_data),
    .ovf_wr   (ovf_wr),
    .cnt_lo   (cnt_lo),
    .cnt_hi   (cnt_hi),
    .ovf_flag (ovf_flag)
);

// File: tb/evtimer16_test.sv
module evtimer16_test;
    localparam int CLK_PERIOD = 10;
    localparam int MC = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        evt_mode = 1'b0;
    logic        evt_pin = 1'b1;
    logic        wr_lo = 1'b0;
    logic        wr_hi = 1'b0;
    logic [15:0] wr_data = '0;
    logic        ovf_wr = 1'b0;
    logic        ovf_wdata = 1'b0;
    logic [7:0]  cnt_lo;
    logic [7:0]  cnt_hi;
    logic        ovf_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evtimer16 uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .evt_mode(evt_mode),
        .evt_pin(evt_pin), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .ovf_wr(ovf_wr), .ovf_wdata(ovf_wdata),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_flag(ovf_flag)
    );

    function automatic logic [15:0] cnt();
        return {cnt_hi, cnt_lo};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Runs the timer until a boundary is seen; returns just after that edge
    task automatic align();
        logic [15:0] v;
        evt_mode = 1'b0;
        run_en   = 1'b1;
        @(negedge clk);
        v = cnt();
        for (int i = 0; i < 3 * MC; i++) begin
            @(negedge clk);
            if (cnt() != v) break;
        end
    endtask

    task automatic t_reset();
        check("R1 count at reset", cnt(), 16'h0000);
        check("R1 flag at reset", ovf_flag, 1'b0);
        rst_n = 1'b1;
        clks(MC * 2);
        check("R1 count held while stopped", cnt(), 16'h0000);
    endtask

    task automatic t_timer();
        logic [15:0] v;
        align();
        v = cnt();
        clks(MC - 1);
        check("R10 no change inside machine cycle", cnt(), v);
        clks(1);
        check("R2 one step at boundary", cnt(), v + 16'd1);
        clks(MC * 5);
        check("R2 five more machine cycles", cnt(), v + 16'd6);
    endtask

    task automatic t_events();
        logic [15:0] v;
        align();
        evt_pin  = 1'b1;
        evt_mode = 1'b1;
        v = cnt();
        clks(MC);
        check("R3 high sample alone counts nothing", cnt(), v);
        evt_pin = 1'b0;
        clks(MC);
        check("R4 not visible at detecting boundary", cnt(), v);
        clks(MC);
        check("R3 fall counted one cycle later", cnt(), v + 16'd1);
        // short low pulse between two sampling edges
        v = cnt();
        evt_pin = 1'b1;
        clks(MC);
        evt_pin = 1'b0;
        clks(4);
        evt_pin = 1'b1;
        clks(MC - 4);
        clks(MC * 2);
        check("R5 glitch between samples ignored", cnt(), v);
        // toggle every machine cycle: four falls over 96 clocks
        v = cnt();
        for (int i = 0; i < 4; i++) begin
            evt_pin = 1'b0;
            clks(MC);
            evt_pin = 1'b1;
            clks(MC);
        end
        clks(MC * 2);
        check("R5 one count per 24 clocks", cnt(), v + 16'd4);
    endtask

    task automatic t_stopped();
        logic [15:0] v;
        align();
        v = cnt();
        run_en = 1'b0;
        clks(MC * 3);
        check("R6 timer frozen when stopped", cnt(), v);
        evt_mode = 1'b1;
        evt_pin  = 1'b0;
        run_en   = 1'b1;
        clks(MC * 3);
        run_en = 1'b0;
        v = cnt();
        evt_pin = 1'b1;
        clks(MC);
        check("R6 counter frozen when stopped", cnt(), v);
        run_en  = 1'b1;
        evt_pin = 1'b0;
        clks(MC * 2);
        check("R6 high sampled while stopped is used", cnt(), v + 16'd1);
        evt_pin = 1'b1;
    endtask

    task automatic t_writes();
        logic [7:0] hv;
        align();
        hv = cnt_hi;
        clks(MC - 1);
        wr_lo   = 1'b1;
        wr_data = 16'h3355;
        clks(1);
        wr_lo = 1'b0;
        check("R9 low write beats increment", cnt_lo, 8'h55);
        check("R9 high byte untouched", cnt_hi, hv);
        clks(MC - 1);
        check("R9 value held until next boundary", cnt_lo, 8'h55);
        clks(1);
        check("R9 counting resumes after write", cnt_lo, 8'h56);
        wr_hi   = 1'b1;
        wr_data = 16'hA700;
        clks(1);
        wr_hi = 1'b0;
        check("R9 high write", cnt(), 16'hA756);
    endtask

    task automatic t_overflow();
        align();
        wr_lo   = 1'b1;
        wr_hi   = 1'b1;
        wr_data = 16'hFFFF;
        clks(1);
        wr_lo = 1'b0;
        wr_hi = 1'b0;
        ovf_wr = 1'b1; ovf_wdata = 1'b0;
        clks(1);
        ovf_wr = 1'b0;
        clks(MC - 3);
        check("R7 top value before rollover", cnt(), 16'hFFFF);
        check("R7 flag clear before rollover", ovf_flag, 1'b0);
        clks(1);
        check("R7 rollover to zero", cnt(), 16'h0000);
        check("R7 flag set on rollover", ovf_flag, 1'b1);
        clks(MC);
        check("R8 flag sticky while counting", ovf_flag, 1'b1);
        check("R7 count continues from zero", cnt(), 16'h0001);
        ovf_wr = 1'b1; ovf_wdata = 1'b0;
        clks(1);
        ovf_wr = 1'b0;
        check("R8 software clear", ovf_flag, 1'b0);
        wr_lo = 1'b1; wr_hi = 1'b1; wr_data = 16'hFFFF;
        clks(1);
        wr_lo = 1'b0; wr_hi = 1'b0;
        clks(MC - 3);
        ovf_wr = 1'b1; ovf_wdata = 1'b0;
        clks(1);
        ovf_wr = 1'b0;
        check("R8 rollover beats clear", ovf_flag, 1'b1);
        check("R8 rollover count", cnt(), 16'h0000);
    endtask

    initial begin
        clks(3);
        t_reset();
        t_timer();
        t_events();
        t_stopped();
        t_writes();
        t_overflow();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule